// File: doc/BRIEF.md
# Floppy Interface Interrupt and Wait Control

This block sits between an 8-bit CPU port bus and a floppy disk controller. It has two write ports and one read port. The drive select latch holds the one-hot drive choice, the recording density and a request for CPU wait states. The interrupt mask register decides which controller conditions may raise the non-maskable interrupt. The interrupt status register lets the CPU see which condition is active, with an active condition reading as 0.

Software sets the wait bit in the latch so that the CPU stalls until the controller is ready. The controller's interrupt request, data request or reset then releases the stall. If none of these arrives, an internal timeout releases it after a fixed number of cycles, so the CPU cannot stay stalled.

Top module: `floppy_irq_wait_ctl`

## Requirements
- R1: After reset, drv_sel is 0000, dbl_density, ext_drive, drive_active, cpu_wait and nmi_req are all 0, and the interrupt mask is cleared.
- R2: A write to the drive port (default 8'hF4) loads the latch in the following cycle. drv_sel takes data bits 3:0 (bit n selects drive n), and dbl_density takes data bit 7 (0 = single density, 1 = double density).
- R3: ext_drive is 1 exactly when drv_sel bit 2 or bit 3 is set.
- R4: drive_active is 1 exactly when any drv_sel bit is set.
- R5: A drive-port write with data bit 6 = 1 raises cpu_wait in the following cycle, unless a release condition is present in the same cycle.
- R6: While cpu_wait is high, a high level on fdc_intrq, fdc_drq or fdc_reset at a clock edge makes cpu_wait low after that edge.
- R7: With no release condition, cpu_wait stays high for exactly WAIT_TMO cycles and then drops.
- R8: A write to the interrupt port (default 8'hE4) loads the mask from data bit 7 (enables fdc_intrq) and data bit 6 (enables motor_tmo). nmi_req is the OR of each enabled source.
- R9: A read of the interrupt port (io_rd high, address 8'hE4) returns bit 7 = NOT fdc_intrq, bit 6 = NOT motor_tmo, and bits 5:0 = 1. At any other time io_rdata is 8'h00.
- R10: A write to any other address leaves the latch outputs, cpu_wait and the mask unchanged.
- R11: nmi_req is a level. It falls in the same cycle that its enabled source goes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_addr | input | 8 | Port address |
| io_wdata | input | 8 | Write data |
| io_wr | input | 1 | Write strobe, one cycle per write |
| io_rd | input | 1 | Read strobe |
| io_rdata | output | 8 | Read data |
| fdc_intrq | input | 1 | Controller interrupt request |
| fdc_drq | input | 1 | Controller data request |
| fdc_reset | input | 1 | Controller reset level |
| motor_tmo | input | 1 | Motor timeout indication |
| drv_sel | output | 4 | One-hot drive selects |
| ext_drive | output | 1 | Drive 2 or 3 selected (external bus) |
| drive_active | output | 1 | Any drive selected |
| dbl_density | output | 1 | Density select |
| nmi_req | output | 1 | Non-maskable interrupt request |
| cpu_wait | output | 1 | Wait request to the CPU |

## Verification
The hardest case to reach is the timeout path. A release input or a new latch write during the window would hide it. The bench therefore raises the wait bit with every controller input held low and counts negative edges, checking cpu_wait high on the last cycle of the window and low on the cycle after it. It also raises a wait with a release input already high, to exercise the set-versus-release priority.

// File: rtl/floppy_glue_pkg.sv
package floppy_glue_pkg;
   // Field order follows the latch bit positions that the outputs decode.
   typedef struct packed {
      logic       dbl;       // bit 7
      logic       wait_req;  // bit 6
      logic [1:0] spare;     // bits 5:4
      logic [3:0] sel;       // bits 3:0
   } drv_latch_t;

   localparam int NUM_IRQ_SRC = 2;  // [1] controller interrupt, [0] motor timeout
endpackage

// File: rtl/floppy_port_regs.sv
module floppy_port_regs
   import floppy_glue_pkg::*;
#(
   parameter int         ADDR_W   = 8,
   parameter logic [7:0] DRV_PORT = 8'hF4,
   parameter logic [7:0] IRQ_PORT = 8'hE4
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [ADDR_W-1:0]      io_addr,
   input  logic [7:0]             io_wdata,
   input  logic                   io_wr,
   output drv_latch_t             latch,
   output logic [NUM_IRQ_SRC-1:0] mask,
   output logic                   wait_set
);
   localparam logic [ADDR_W-1:0] DRV_A = ADDR_W'(DRV_PORT);
   localparam logic [ADDR_W-1:0] IRQ_A = ADDR_W'(IRQ_PORT);

   initial begin
      if (DRV_PORT == IRQ_PORT) $error("port addresses must differ");
   end

   logic drv_wr, irq_wr;
   assign drv_wr   = io_wr && (io_addr == DRV_A);
   assign irq_wr   = io_wr && (io_addr == IRQ_A);
   assign wait_set = drv_wr && io_wdata[6];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         latch <= '0;
         mask  <= '0;
      end else begin
         if (drv_wr) latch <= drv_latch_t'(io_wdata);
         if (irq_wr) mask  <= io_wdata[7 -: NUM_IRQ_SRC];
      end
   end

   // R10: writes elsewhere do not disturb either register
   a_r10_other_addr_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (io_wr && io_addr != DRV_A && io_addr != IRQ_A) |=> ($stable(latch) && $stable(mask)));
   // R2: drive-port write lands in the latch
   a_r2_latch_load: assert property (@(posedge clk) disable iff (!rst_n)
      drv_wr |=> (latch == drv_latch_t'($past(io_wdata))));
endmodule

// File: rtl/floppy_wait_gen.sv
module floppy_wait_gen #(
   parameter int WAIT_TMO = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic wait_set,
   input  logic fdc_intrq,
   input  logic fdc_drq,
   input  logic fdc_reset,
   output logic cpu_wait
);
   localparam int CNT_W = $clog2(WAIT_TMO + 1);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(WAIT_TMO - 1);

   initial begin
      if (WAIT_TMO < 2) $error("WAIT_TMO must be at least 2");
   end

   logic [CNT_W-1:0] cnt;
   logic             ext_release, tmo_hit;

   assign ext_release = fdc_intrq | fdc_drq | fdc_reset;
   assign tmo_hit     = cpu_wait && (cnt == LAST);

   // Release beats set; timeout ends the window after WAIT_TMO cycles.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cpu_wait <= 1'b0;
         cnt      <= '0;
      end else if (ext_release || tmo_hit) begin
         cpu_wait <= 1'b0;
         cnt      <= '0;
      end else if (wait_set) begin
         cpu_wait <= 1'b1;
         cnt      <= '0;
      end else if (cpu_wait) begin
         cnt      <= cnt + 1'b1;
      end
   end

   // R5
   a_r5_wait_raise: assert property (@(posedge clk) disable iff (!rst_n)
      (wait_set && !ext_release && !tmo_hit) |=> cpu_wait);
   // R6
   a_r6_wait_release: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_wait && ext_release) |=> !cpu_wait);
   // R7: counter stays inside the window
   a_r7_window_bound: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_wait |-> (cnt <= LAST));
   a_r7_idle_counter: assert property (@(posedge clk) disable iff (!rst_n)
      !cpu_wait |-> (cnt == '0));
endmodule

// File: rtl/floppy_irq_status.sv
module floppy_irq_status
   import floppy_glue_pkg::*;
#(
   parameter int         ADDR_W   = 8,
   parameter logic [7:0] IRQ_PORT = 8'hE4
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [ADDR_W-1:0]      io_addr,
   input  logic                   io_rd,
   input  logic [NUM_IRQ_SRC-1:0] src,
   input  logic [NUM_IRQ_SRC-1:0] mask,
   output logic                   nmi_req,
   output logic [7:0]             io_rdata
);
   localparam logic [ADDR_W-1:0] IRQ_A = ADDR_W'(IRQ_PORT);
   localparam int FILL_W = 8 - NUM_IRQ_SRC;

   logic [NUM_IRQ_SRC-1:0] gated;
   for (genvar i = 0; i < NUM_IRQ_SRC; i++) begin : g_src
      assign gated[i] = src[i] & mask[i];
   end
   assign nmi_req = |gated;

   logic [7:0] status;
   assign status   = {~src, {FILL_W{1'b1}}};
   assign io_rdata = (io_rd && io_addr == IRQ_A) ? status : 8'h00;

   // R11: no active source, no interrupt
   a_r11_nmi_level: assert property (@(posedge clk) disable iff (!rst_n)
      (src == '0) |-> !nmi_req);
   // R8: cleared mask blocks all sources
   a_r8_mask_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      (mask == '0) |-> !nmi_req);
   // R9: bus idle when not reading
   a_r9_idle_bus: assert property (@(posedge clk) disable iff (!rst_n)
      !io_rd |-> (io_rdata == 8'h00));
endmodule

// File: rtl/floppy_irq_wait_ctl.sv
module floppy_irq_wait_ctl
   import floppy_glue_pkg::*;
#(
   parameter int         ADDR_W   = 8,
   parameter logic [7:0] DRV_PORT = 8'hF4,
   parameter logic [7:0] IRQ_PORT = 8'hE4,
   parameter int         WAIT_TMO = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] io_addr,
   input  logic [7:0]        io_wdata,
   input  logic              io_wr,
   input  logic              io_rd,
   output logic [7:0]        io_rdata,
   input  logic              fdc_intrq,
   input  logic              fdc_drq,
   input  logic              fdc_reset,
   input  logic              motor_tmo,
   output logic [3:0]        drv_sel,
   output logic              ext_drive,
   output logic              drive_active,
   output logic              dbl_density,
   output logic              nmi_req,
   output logic              cpu_wait
);
   initial begin
      if (ADDR_W < 8) $error("ADDR_W must cover 8-bit port addresses");
   end

   drv_latch_t             latch;
   logic [NUM_IRQ_SRC-1:0] mask;
   logic                   wait_set;

   floppy_port_regs #(.ADDR_W(ADDR_W), .DRV_PORT(DRV_PORT), .IRQ_PORT(IRQ_PORT)) u_regs (
      .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wdata(io_wdata), .io_wr(io_wr),
      .latch(latch), .mask(mask), .wait_set(wait_set));

   floppy_wait_gen #(.WAIT_TMO(WAIT_TMO)) u_wait (
      .clk(clk), .rst_n(rst_n), .wait_set(wait_set), .fdc_intrq(fdc_intrq),
      .fdc_drq(fdc_drq), .fdc_reset(fdc_reset), .cpu_wait(cpu_wait));

   floppy_irq_status #(.ADDR_W(ADDR_W), .IRQ_PORT(IRQ_PORT)) u_irq (
      .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_rd(io_rd),
      .src({fdc_intrq, motor_tmo}), .mask(mask), .nmi_req(nmi_req), .io_rdata(io_rdata));

   assign drv_sel      = latch.sel;
   assign dbl_density  = latch.dbl;
   assign ext_drive    = latch.sel[2] | latch.sel[3];
   assign drive_active = |latch.sel;

   // R3: external flag implies a drive is selected
   a_r3_ext_implies_active: assert property (@(posedge clk) disable iff (!rst_n)
      ext_drive |-> drive_active);
   // R4: no drive bit, no indication
   a_r4_active_needs_sel: assert property (@(posedge clk) disable iff (!rst_n)
      (drv_sel == 4'b0000) |-> !drive_active);
endmodule

// File: tb/floppy_irq_wait_ctl_bench.sv
module floppy_irq_wait_ctl_bench;
   localparam int TMO = 16;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [7:0] io_addr = '0, io_wdata = '0, io_rdata;
   logic io_wr = 1'b0, io_rd = 1'b0;
   logic fdc_intrq = 1'b0, fdc_drq = 1'b0, fdc_reset = 1'b0, motor_tmo = 1'b0;
   logic [3:0] drv_sel;
   logic ext_drive, drive_active, dbl_density, nmi_req, cpu_wait;
   int n_cmp = 0, n_bad = 0;

   always #2 clk = ~clk;

   floppy_irq_wait_ctl #(.WAIT_TMO(TMO)) u_floppy_irq_wait_ctl (
      .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wdata(io_wdata), .io_wr(io_wr),
      .io_rd(io_rd), .io_rdata(io_rdata), .fdc_intrq(fdc_intrq), .fdc_drq(fdc_drq),
      .fdc_reset(fdc_reset), .motor_tmo(motor_tmo), .drv_sel(drv_sel), .ext_drive(ext_drive),
      .drive_active(drive_active), .dbl_density(dbl_density), .nmi_req(nmi_req),
      .cpu_wait(cpu_wait));

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [7:0] d);
      io_addr = a; io_wdata = d; io_wr = 1'b1;
      @(negedge clk);
      io_wr = 1'b0; io_wdata = '0;
   endtask

   task automatic show_latch(input string req, input logic [7:0] d);
      chk(req, {4'h0, drv_sel}, {4'h0, d[3:0]});
      chk(req, {7'h0, dbl_density}, {7'h0, d[7]});
      chk(req, {7'h0, ext_drive}, {7'h0, d[2] | d[3]});
      chk(req, {7'h0, drive_active}, {7'h0, d[3:0] != 4'h0});
   endtask

   initial begin
      #400000;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      chk("R1 sel", {4'h0, drv_sel}, 8'h00);
      chk("R1 flags", {3'b0, dbl_density, ext_drive, drive_active, nmi_req, cpu_wait}, 8'h00);
      fdc_intrq = 1'b1; motor_tmo = 1'b1; #0;
      chk("R1 mask clear", {7'h0, nmi_req}, 8'h00);
      fdc_intrq = 1'b0; motor_tmo = 1'b0;

      // R2 R3 R4 sweep of select nibble and density, wait bit held off
      for (int v = 0; v < 32; v++) begin
         logic [7:0] d;
         d = {v[4], 1'b0, 2'b00, v[3:0]};
         wr(8'hF4, d);
         show_latch("R2 R3 R4 sweep", d);
         chk("R5 no wait without bit6", {7'h0, cpu_wait}, 8'h00);
      end

      // R10 other addresses ignored
      wr(8'hF4, 8'h85);
      wr(8'hE4, 8'h00);
      for (int a = 0; a < 256; a += 7) begin
         if (a != 8'hF4 && a != 8'hE4) begin
            wr(8'(a), 8'hFF);
            show_latch("R10 latch kept", 8'h85);
            chk("R10 wait kept", {7'h0, cpu_wait}, 8'h00);
            fdc_intrq = 1'b1; motor_tmo = 1'b1; #0;
            chk("R10 mask kept", {7'h0, nmi_req}, 8'h00);
            fdc_intrq = 1'b0; motor_tmo = 1'b0;
         end
      end

      // R8 R9 R11 mask x source sweep
      for (int m = 0; m < 4; m++) begin
         wr(8'hE4, {m[1:0], 6'h00});
         for (int s = 0; s < 4; s++) begin
            fdc_intrq = s[1]; motor_tmo = s[0]; io_addr = 8'hE4; io_rd = 1'b1; #1;
            chk("R8 nmi", {7'h0, nmi_req}, {7'h0, (m[1] & s[1]) | (m[0] & s[0])});
            chk("R9 status", io_rdata, {~s[1], ~s[0], 6'h3F});
            io_addr = 8'hF4; #1;
            chk("R9 other addr", io_rdata, 8'h00);
            io_rd = 1'b0; #1;
            chk("R9 no read", io_rdata, 8'h00);
            fdc_intrq = 1'b0; motor_tmo = 1'b0; #1;
            chk("R11 nmi drops", {7'h0, nmi_req}, 8'h00);
            @(negedge clk);
         end
      end

      // R5 R6 each release source
      for (int r = 0; r < 3; r++) begin
         wr(8'hF4, 8'h41);
         chk("R5 wait raised", {7'h0, cpu_wait}, 8'h01);
         show_latch("R2 with wait", 8'h41);
         @(negedge clk);
         fdc_intrq = (r == 0); fdc_drq = (r == 1); fdc_reset = (r == 2);
         @(negedge clk);
         chk("R6 released", {7'h0, cpu_wait}, 8'h00);
         fdc_intrq = 1'b0; fdc_drq = 1'b0; fdc_reset = 1'b0;
         @(negedge clk);
         chk("R6 stays low", {7'h0, cpu_wait}, 8'h00);
      end

      // R5 release present in same cycle as set
      fdc_drq = 1'b1;
      wr(8'hF4, 8'h40);
      chk("R5 release wins", {7'h0, cpu_wait}, 8'h00);
      fdc_drq = 1'b0;

      // R7 timeout
      wr(8'hF4, 8'h42);
      chk("R7 start", {7'h0, cpu_wait}, 8'h01);
      repeat (TMO - 1) @(negedge clk);
      chk("R7 last cycle", {7'h0, cpu_wait}, 8'h01);
      @(negedge clk);
      chk("R7 timed out", {7'h0, cpu_wait}, 8'h00);
      show_latch("R7 latch kept", 8'h42);

      // R7 rewrite restarts window
      wr(8'hF4, 8'h40);
      repeat (5) @(negedge clk);
      wr(8'hF4, 8'h40);
      repeat (TMO - 1) @(negedge clk);
      chk("R7 restarted", {7'h0, cpu_wait}, 8'h01);
      @(negedge clk);
      chk("R7 restarted end", {7'h0, cpu_wait}, 8'h00);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule